// File: doc/BRIEF.md
# Two-Level Interrupt Arbiter

This block sits between seven maskable interrupt sources and a small CPU core. It holds the per-source enable bits, one global enable and one priority-level bit per source. It picks one winner among the pending, enabled requests, and it signals the CPU to vector with a single-cycle pulse and a 3-bit source index. A winner is chosen in two steps: sources marked high-priority beat all others, and a fixed natural order breaks ties inside a level.

Software writes the settings through a plain write port. That port has a 2-bit register address and an 8-bit data word. When a request is taken, the block marks its level as in service. While a level is in service, that level and any lower level are blocked. A low-level service can still be preempted by a high-level request. A return-from-interrupt strobe from the CPU releases the most recently entered level.

Source indices: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial, 5 = timer 2, 6 = ADC. Request input bit i belongs to source i.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all enable bits, all priority bits and both in-service bits are zero, and vecReq is low. Requests alone cause no vector.
- R2: Register address 0 holds the global enable at data bit 7. While this bit is zero, no request is taken.
- R3: Address 0 data bits 0 to 5 enable sources 0 to 5. Address 1 data bit 0 enables source 6. A source whose enable bit is clear is never taken.
- R4: When several requests at the same level are pending, the lowest source index wins.
- R5: Address 2 data bits 0 to 5 give sources 0 to 5 the high level. Address 3 data bit 3 gives source 6 the high level. A pending high-level source wins over every pending low-level source. Address 2 bits 6 and 7 and every address 3 bit except bit 3 have no effect.
- R6: A request taken at clock edge k drives vecReq high for the one cycle after edge k. vecIdx carries the winner's index in that same cycle, and the in-service bit of the winner's level (bit 1 for high, bit 0 for low) is set from that same edge.
- R7: While ackBusy is high, no vector pulse is issued. The pending winner is taken on the first cycle in which ackBusy is low.
- R8: A high-level request preempts a low-level service. No request is taken while the high level is in service. While the low level is in service, only high-level requests are taken.
- R9: A retStrobe clears the highest set in-service bit. If a request is taken in the same cycle, its level bit is set as well.
- R10: A register write takes effect from the next cycle. Arbitration in the write cycle uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 enables, 1 ADC enable, 2 priorities, 3 ADC priority |
| regWdata | input | 8 | Write data |
| irqReq | input | 7 | Pending request per source, bit i = source i |
| ackBusy | input | 1 | CPU cannot accept a vector this cycle |
| retStrobe | input | 1 | Return-from-interrupt, releases one level |
| vecReq | output | 1 | One-cycle vector request pulse |
| vecIdx | output | 3 | Index of the winning source |
| inServ | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The assertions watch on every cycle the rules that relate the ports over time. They check that the busy input suppresses the pulse and that an in-service high level blocks every vector. They also check that a low service only yields to a high request, that a return clears the right in-service bit, and that the high in-service bit never rises without a pulse. Which index wins depends on the enable, global and priority settings and on the natural order. Only the bench's directed and random scenarios can show that, by comparing the results against a reference model. The same applies to the write-cycle timing and to the unused register bits having no effect.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int SRC_COUNT   = 7;
  localparam int WDATA_W     = 8;
  localparam int RADDR_W     = 2;
  // register address codes
  localparam int ADDR_EN0    = 0;
  localparam int ADDR_EN1    = 1;
  localparam int ADDR_PRI0   = 2;
  localparam int ADDR_PRI1   = 3;
  // bit positions that software relies on
  localparam int GLOBAL_BIT  = 7;
  localparam int EN1_BIT     = 0;
  localparam int PRI1_BIT    = 3;

  typedef struct packed {
    logic fire;      // take a winner this cycle
    logic takeHigh;  // winner comes from the high level
    logic popLevel;  // release the top in-service level
  } ctlStrobe_t;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int N  = 7,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import prio_irq_pkg::*;
(
  input  logic       hiPend,
  input  logic       loPend,
  input  logic [1:0] inServ,
  input  logic       ackBusy,
  input  logic       retStrobe,
  output ctlStrobe_t strobe
);
  logic canHigh, canLow;

  assign canHigh = hiPend && !inServ[1];
  assign canLow  = loPend && (inServ == 2'b00);

  always_comb begin
    strobe.fire     = !ackBusy && (canHigh || canLow);
    strobe.takeHigh = canHigh;
    strobe.popLevel = retStrobe;
  end
endmodule

// File: rtl/prio_irq_dp.sv
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int DATA_W  = WDATA_W,
  parameter int ADDR_W  = RADDR_W,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] irqReq,
  input  ctlStrobe_t         strobe,
  output logic               hiPend,
  output logic               loPend,
  output logic [1:0]         inServ,
  output logic               vecReq,
  output logic [IDX_W-1:0]   vecIdx
);
  localparam int LEVELS = 2;

  logic [NUM_SRC-1:0] srcEn, srcPri, effReq;
  logic [NUM_SRC-1:0] lvlReq [LEVELS];
  logic [IDX_W-1:0]   lvlIdx [LEVELS];
  logic [LEVELS-1:0]  lvlAny;
  logic               globalEn;
  logic [1:0]         inServNxt;
  logic [IDX_W-1:0]   winIdx;
  logic               unusedWdata;

  assign unusedWdata = ^regWdata;

  // per-source enable and level bits; the last source lives in the second registers
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic enQ, priQ;
    if (i < NUM_SRC - 1) begin : g_main
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          enQ  <= 1'b0;
          priQ <= 1'b0;
        end else if (regWe) begin
          if (regAddr == ADDR_W'(ADDR_EN0))  enQ  <= regWdata[i];
          if (regAddr == ADDR_W'(ADDR_PRI0)) priQ <= regWdata[i];
        end
      end
    end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          enQ  <= 1'b0;
          priQ <= 1'b0;
        end else if (regWe) begin
          if (regAddr == ADDR_W'(ADDR_EN1))  enQ  <= regWdata[EN1_BIT];
          if (regAddr == ADDR_W'(ADDR_PRI1)) priQ <= regWdata[PRI1_BIT];
        end
      end
    end
    assign srcEn[i]  = enQ;
    assign srcPri[i] = priQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) globalEn <= 1'b0;
    else if (regWe && regAddr == ADDR_W'(ADDR_EN0)) globalEn <= regWdata[GLOBAL_BIT];
  end

  assign effReq    = irqReq & srcEn & {NUM_SRC{globalEn}};
  assign lvlReq[0] = effReq & ~srcPri;
  assign lvlReq[1] = effReq & srcPri;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    prio_irq_pick #(.N(NUM_SRC), .IW(IDX_W)) u_pick (
      .vec(lvlReq[l]),
      .any(lvlAny[l]),
      .idx(lvlIdx[l])
    );
  end

  assign hiPend = lvlAny[1];
  assign loPend = lvlAny[0];
  assign winIdx = strobe.takeHigh ? lvlIdx[1] : lvlIdx[0];

  always_comb begin
    inServNxt = inServ;
    if (strobe.popLevel) begin
      if (inServ[1]) inServNxt[1] = 1'b0;
      else           inServNxt[0] = 1'b0;
    end
    if (strobe.fire) inServNxt[strobe.takeHigh] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inServ <= 2'b00;
      vecReq <= 1'b0;
      vecIdx <= '0;
    end else begin
      inServ <= inServNxt;
      vecReq <= strobe.fire;
      if (strobe.fire) vecIdx <= winIdx;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int DATA_W  = WDATA_W,
  parameter int ADDR_W  = RADDR_W,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               ackBusy,
  input  logic               retStrobe,
  output logic               vecReq,
  output logic [IDX_W-1:0]   vecIdx,
  output logic [1:0]         inServ
);
  ctlStrobe_t strobe;
  logic       hiPend, loPend;

  prio_irq_ctl u_ctl (
    .hiPend(hiPend),
    .loPend(loPend),
    .inServ(inServ),
    .ackBusy(ackBusy),
    .retStrobe(retStrobe),
    .strobe(strobe)
  );

  prio_irq_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .regWe(regWe),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .irqReq(irqReq),
    .strobe(strobe),
    .hiPend(hiPend),
    .loPend(loPend),
    .inServ(inServ),
    .vecReq(vecReq),
    .vecIdx(vecIdx)
  );
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC = 7,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ackBusy,
  input logic             retStrobe,
  input logic             vecReq,
  input logic [IDX_W-1:0] vecIdx,
  input logic [1:0]       inServ
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (inServ == 2'b00 && !vecReq));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ackBusy |=> !vecReq);

  // R8
  high_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inServ[1] && !retStrobe) |=> !vecReq);

  // R8
  low_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inServ[0] && !retStrobe) |=> (!vecReq || inServ[1]));

  // R9
  pop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retStrobe && inServ[1]) |=> !inServ[1]);

  // R9
  pop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retStrobe && inServ == 2'b01) |=> !inServ[0]);

  // R6
  pulse_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vecReq |-> (inServ != 2'b00 && vecIdx < IDX_W'(NUM_SRC)));

  // R6
  high_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inServ[1]) |-> vecReq);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ackBusy(ackBusy),
  .retStrobe(retStrobe),
  .vecReq(vecReq),
  .vecIdx(vecIdx),
  .inServ(inServ)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [6:0] irqReq = '0;
  logic       ackBusy = 1'b0;
  logic       retStrobe = 1'b0;
  logic       vecReq;
  logic [2:0] vecIdx;
  logic [1:0] inServ;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [6:0] mEn = '0, mPri = '0;
  logic       mEa = 1'b0;
  logic [1:0] mIns = 2'b00;

  always #2.5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .irqReq(irqReq), .ackBusy(ackBusy), .retStrobe(retStrobe),
    .vecReq(vecReq), .vecIdx(vecIdx), .inServ(inServ)
  );

  function automatic logic [2:0] lowest(input logic [6:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 6; i >= 0; i--) if (v[i]) r = 3'(i);
    return r;
  endfunction

  task automatic cyc(input string tag, input logic we, input logic [1:0] a, input logic [7:0] d,
                     input logic [6:0] rq, input logic bz, input logic rt);
    logic [6:0] eff, hi, lo;
    logic       fire, lvl;
    logic [2:0] idx;
    logic [1:0] nIns;
    regWe = we; regAddr = a; regWdata = d; irqReq = rq; ackBusy = bz; retStrobe = rt;
    eff = rq & mEn & {7{mEa}};
    hi = eff & mPri;
    lo = eff & ~mPri;
    fire = 1'b0; lvl = 1'b0; idx = 3'd0;
    if (!bz && hi != 0 && !mIns[1]) begin fire = 1'b1; lvl = 1'b1; idx = lowest(hi); end
    else if (!bz && lo != 0 && mIns == 2'b00) begin fire = 1'b1; idx = lowest(lo); end
    nIns = mIns;
    if (rt) begin
      if (nIns[1]) nIns[1] = 1'b0;
      else nIns[0] = 1'b0;
    end
    if (fire) nIns[lvl] = 1'b1;
    mIns = nIns;
    if (we) begin
      case (a)
        2'd0: begin mEn[5:0] = d[5:0]; mEa = d[7]; end
        2'd1: mEn[6] = d[0];
        2'd2: mPri[5:0] = d[5:0];
        default: mPri[6] = d[3];
      endcase
    end
    @(negedge clk);
    checks++;
    if (vecReq !== fire || (fire && vecIdx !== idx) || inServ !== nIns) begin
      errors++;
      $display("FAIL %s: vecReq=%0b vecIdx=%0d inServ=%b expected vecReq=%0b vecIdx=%0d inServ=%b",
               tag, vecReq, vecIdx, inServ, fire, idx, nIns);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R6: watchdog expired, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checks++;
    if (vecReq !== 1'b0 || inServ !== 2'b00) begin
      errors++;
      $display("FAIL R1: vecReq=%0b inServ=%b expected 0 00", vecReq, inServ);
    end
    rst_n = 1'b1;
    // R1: nothing enabled after reset
    cyc("R1", 0, 0, 8'h00, 7'h7F, 0, 0);
    cyc("R1", 0, 0, 8'h00, 7'h7F, 0, 0);
    // R2: sources enabled but global bit clear
    cyc("R2", 1, 0, 8'h3F, 7'h7F, 0, 0);
    cyc("R3", 1, 1, 8'h01, 7'h7F, 0, 0);
    cyc("R2", 0, 0, 8'h00, 7'h7F, 0, 0);
    // R10: write cycle still uses old settings, then source 0 wins
    cyc("R10", 1, 0, 8'hBF, 7'h7F, 0, 0);
    cyc("R2", 0, 0, 8'h00, 7'h7F, 0, 0);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    // R4: natural order
    cyc("R4", 0, 0, 8'h00, 7'b1010100, 0, 0);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    cyc("R3", 0, 0, 8'h00, 7'b1000000, 0, 0);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    // R3: ADC enable cleared
    cyc("R3", 1, 1, 8'hFE, 7'h00, 0, 0);
    cyc("R3", 0, 0, 8'h00, 7'b1000000, 0, 0);
    cyc("R3", 1, 1, 8'h01, 7'h00, 0, 0);
    // R5: ADC raised to high level
    cyc("R5", 1, 3, 8'h08, 7'h00, 0, 0);
    cyc("R5", 0, 0, 8'h00, 7'h7F, 0, 0);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    // R5: unused bits only
    cyc("R5", 1, 3, 8'hF7, 7'h00, 0, 0);
    cyc("R5", 1, 2, 8'hC0, 7'h00, 0, 0);
    cyc("R5", 0, 0, 8'h00, 7'h7F, 0, 0);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    // R8: preemption and blocking
    cyc("R8", 1, 2, 8'h10, 7'h00, 0, 0);
    cyc("R8", 0, 0, 8'h00, 7'b0000001, 0, 0);
    cyc("R8", 0, 0, 8'h00, 7'b0000011, 0, 0);
    cyc("R8", 0, 0, 8'h00, 7'b0010000, 0, 0);
    cyc("R8", 0, 0, 8'h00, 7'b0010001, 0, 0);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    // R7: busy holds off
    cyc("R7", 0, 0, 8'h00, 7'b0000001, 1, 0);
    cyc("R7", 0, 0, 8'h00, 7'b0000001, 1, 0);
    cyc("R7", 0, 0, 8'h00, 7'b0000001, 0, 0);
    // R9: return and high take in one cycle
    cyc("R9", 0, 0, 8'h00, 7'b0010000, 0, 1);
    cyc("R9", 0, 0, 8'h00, 7'h00, 0, 1);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic       we, bz, rt;
      logic [1:0] a;
      logic [7:0] d;
      logic [6:0] rq;
      we = ($urandom % 8) == 0;
      a  = 2'($urandom);
      d  = 8'($urandom);
      if (a == 2'd0 && ($urandom % 4) != 0) d[7] = 1'b1;
      rq = 7'($urandom) & 7'($urandom);
      bz = ($urandom % 4) == 0;
      rt = ($urandom % 3) == 0;
      cyc("R6", we, a, d, rq, bz, rt);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule